// File: doc/BRIEF.md
# Service-Slave Configuration Window Decoder

This block decodes word accesses into the 2 MiB address window of a remote service slave. The window has three live regions. The first is a read-only configuration table that describes the slave. It begins with a fixed chip identifier and continues with packed engine descriptor words. The second is a file of plain control words. The third is a local bus whose only engine is a four-word scratchpad. Every other address reads as zero and ignores writes.

Software finds the slave by walking the table. Each descriptor carries a continuation flag, a slot count, a version, an engine type and a check nibble. A break command word written into the first two table words resets every local-bus engine. The reset goes out on a one-cycle strobe, and the scratchpad clears in the same cycle.

Requests take one cycle. Read data is registered and comes back with a valid flag one cycle after the request. Data words pass through unchanged, with bit 31 as the first (most significant) byte on the bus.

Top module: `cfg_window_decoder`

## Requirements
- R1: After reset `rdValid` and `lbusReset` are low, and every control word and scratchpad word reads 0.
- R2: A read request is answered in the next cycle with `rdValid` high. Reading byte offset 0x000 returns the chip identifier 0xc0022d15.
- R3: Offsets 0x004, 0x008 and 0x00c return engine descriptors. Each descriptor is the OR of 0x80000000 (continuation flag), 0x00010000 (slot count), the version, the type shifted left by 4, and the check nibble. The three (version, type, check) sets are (0x1000, 2, 0xc), (0x5000, 3, 0xa) and (0x1000, 6, 0x7).
- R4: Table offsets 0x010 to 0x3fc read 0. A table write that is not a break command changes no readable word.
- R5: Offsets 0x800 to 0xbfc hold 256 independent 32-bit read/write control words.
- R6: The scratchpad occupies 0xc00 to 0xc0c as four read/write words. Local-bus offsets from 0xc10 to the end of the window read 0, and writes there are dropped.
- R7: Offsets 0x400 to 0x7fc read 0, and writes there are ignored.
- R8: Writing 0xc0de0000 to table offset 0x000 or 0x004 raises `lbusReset` for exactly the one cycle that follows the write. Any other data value, or any other table offset, leaves it low.
- R9: In the cycle `lbusReset` is high, all scratchpad words become 0. A scratchpad write issued in that cycle is lost. Control words keep their values.
- R10: A scratchpad read issued in the cycle `lbusReset` is high returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Access request this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 21 | Byte address within the window |
| reqWdata | input | 32 | Write data |
| rdValid | output | 1 | Read data valid (one cycle after a read) |
| rdData | output | 32 | Read data |
| lbusReset | output | 1 | One-cycle cold reset strobe to local-bus engines |

## Verification
Two functions can land in the same cycle: the break-driven clear of the scratchpad, and a scratchpad access issued right after the break write. The bench issues a scratchpad write, and separately a scratchpad read, in the exact cycle `lbusReset` is high. It then requires that the written word reads back as 0 and that the read returns 0, not the stale contents. It also checks that control words written before the break survive. Full sweeps of the table, the control file and the unmapped gap surround these collisions.

// File: rtl/cfg_window_pkg.sv
package cfg_window_pkg;
  parameter int ADDR_W        = 21;
  parameter int DATA_W        = 32;
  parameter int CFG_BYTES     = 1024;
  parameter int CTRL_WORDS    = 256;
  parameter int SCRATCH_WORDS = 4;

  localparam int CFG_IDX_W  = $clog2(CFG_BYTES / 4);
  localparam int CTRL_IDX_W = $clog2(CTRL_WORDS);
  localparam int SP_IDX_W   = $clog2(SCRATCH_WORDS);

  localparam logic [ADDR_W-1:0] CFG_LIMIT  = ADDR_W'(CFG_BYTES);
  localparam logic [ADDR_W-1:0] CTRL_BASE  = ADDR_W'(32'h800);
  localparam logic [ADDR_W-1:0] CTRL_LIMIT = ADDR_W'(32'h800 + CTRL_WORDS * 4);
  localparam logic [ADDR_W-1:0] LBUS_BASE  = ADDR_W'(32'hc00);
  localparam logic [ADDR_W-1:0] SP_LIMIT   = ADDR_W'(32'hc00 + SCRATCH_WORDS * 4);

  localparam logic [DATA_W-1:0] CHIP_IDENT = 32'hc0022d15;
  localparam logic [DATA_W-1:0] BREAK_WORD = 32'hc0de0000;
  localparam logic [DATA_W-1:0] DESC_MORE  = 32'h80000000;
  localparam logic [DATA_W-1:0] DESC_SLOTS = 32'h00010000;

  typedef enum logic [1:0] {
    RG_NONE    = 2'd0,
    RG_CFG     = 2'd1,
    RG_CTRL    = 2'd2,
    RG_SCRATCH = 2'd3
  } region_e;

  typedef struct packed {
    logic                  ctrlWr;
    logic                  spWr;
    logic                  spClear;
    logic                  rdEn;
    region_e               rdSel;
    logic [CTRL_IDX_W-1:0] ctrlIdx;
    logic [SP_IDX_W-1:0]   spIdx;
    logic [CFG_IDX_W-1:0]  cfgIdx;
  } strobe_t;

  function automatic logic [DATA_W-1:0] engineDesc(input logic [15:0] ver,
                                                   input logic [3:0] kind,
                                                   input logic [3:0] chk);
    return DESC_MORE | DESC_SLOTS | {16'h0, ver} | {24'h0, kind, 4'h0} | {28'h0, chk};
  endfunction

  function automatic logic [DATA_W-1:0] cfgWord(input logic [CFG_IDX_W-1:0] idx);
    case (idx)
      CFG_IDX_W'(0): return CHIP_IDENT;
      CFG_IDX_W'(1): return engineDesc(16'h1000, 4'd2, 4'hc);
      CFG_IDX_W'(2): return engineDesc(16'h5000, 4'd3, 4'ha);
      CFG_IDX_W'(3): return engineDesc(16'h1000, 4'd6, 4'h7);
      default:       return '0;
    endcase
  endfunction
endpackage

// File: rtl/cfg_window_ctrl.sv
module cfg_window_ctrl
  import cfg_window_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output strobe_t           strobes,
  output logic              lbusReset
);
  region_e              region;
  logic [CFG_IDX_W-1:0] cfgIdx;
  logic                 breakHit;
  logic                 breakQ;

  always_comb begin
    region = RG_NONE;
    if (reqAddr < CFG_LIMIT)
      region = RG_CFG;
    else if (reqAddr >= CTRL_BASE && reqAddr < CTRL_LIMIT)
      region = RG_CTRL;
    else if (reqAddr >= LBUS_BASE && reqAddr < SP_LIMIT)
      region = RG_SCRATCH;
  end

  assign cfgIdx   = reqAddr[CFG_IDX_W+1:2];
  assign breakHit = reqValid && reqWrite && (region == RG_CFG) &&
                    (cfgIdx < CFG_IDX_W'(2)) && (reqWdata == BREAK_WORD);

  always_ff @(posedge clk) begin
    if (!rstN) breakQ <= 1'b0;
    else       breakQ <= breakHit;
  end

  always_comb begin
    strobes.ctrlWr  = reqValid && reqWrite && (region == RG_CTRL);
    strobes.spWr    = reqValid && reqWrite && (region == RG_SCRATCH);
    strobes.spClear = breakQ;
    strobes.rdEn    = reqValid && !reqWrite;
    strobes.rdSel   = region;
    strobes.ctrlIdx = reqAddr[CTRL_IDX_W+1:2];
    strobes.spIdx   = reqAddr[SP_IDX_W+1:2];
    strobes.cfgIdx  = cfgIdx;
  end

  assign lbusReset = breakQ;
endmodule

// File: rtl/cfg_window_dp.sv
module cfg_window_dp
  import cfg_window_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  logic [DATA_W-1:0] wrData,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] ctrlMem [CTRL_WORDS];
  logic [DATA_W-1:0] spMem   [SCRATCH_WORDS];
  logic [DATA_W-1:0] rdMux;

  for (genvar w = 0; w < CTRL_WORDS; w++) begin : g_ctrl
    always_ff @(posedge clk) begin
      if (!rstN)
        ctrlMem[w] <= '0;
      else if (strobes.ctrlWr && strobes.ctrlIdx == CTRL_IDX_W'(w))
        ctrlMem[w] <= wrData;
    end
  end

  for (genvar s = 0; s < SCRATCH_WORDS; s++) begin : g_sp
    always_ff @(posedge clk) begin
      if (!rstN || strobes.spClear)
        spMem[s] <= '0;
      else if (strobes.spWr && strobes.spIdx == SP_IDX_W'(s))
        spMem[s] <= wrData;
    end
  end

  always_comb begin
    case (strobes.rdSel)
      RG_CFG:     rdMux = cfgWord(strobes.cfgIdx);
      RG_CTRL:    rdMux = ctrlMem[strobes.ctrlIdx];
      RG_SCRATCH: rdMux = strobes.spClear ? '0 : spMem[strobes.spIdx];
      default:    rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= strobes.rdEn;
      if (strobes.rdEn) rdData <= rdMux;
    end
  end
endmodule

// File: rtl/cfg_window_decoder.sv
module cfg_window_decoder
  import cfg_window_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic              lbusReset
);
  strobe_t strobes;

  cfg_window_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .strobes  (strobes),
    .lbusReset(lbusReset)
  );

  cfg_window_dp u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .wrData (reqWdata),
    .rdValid(rdValid),
    .rdData (rdData)
  );
endmodule

// File: rtl/cfg_window_chk.sv
module cfg_window_chk
  import cfg_window_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqWrite,
  input logic [ADDR_W-1:0] reqAddr,
  input logic [DATA_W-1:0] reqWdata,
  input logic              rdValid,
  input logic [DATA_W-1:0] rdData,
  input logic              lbusReset
);
  logic isRead;
  logic isGapRead;
  logic isIdentRead;
  logic isBreakCmd;

  assign isRead      = reqValid && !reqWrite;
  assign isGapRead   = isRead && reqAddr >= CFG_LIMIT && reqAddr < CTRL_BASE;
  assign isIdentRead = isRead && reqAddr[ADDR_W-1:2] == '0;
  assign isBreakCmd  = reqValid && reqWrite && reqWdata == BREAK_WORD &&
                       reqAddr[ADDR_W-1:2] < (ADDR_W-2)'(2);

  assert_rd_resp_R2: assert property (@(posedge clk) disable iff (!rstN)
    isRead |=> rdValid);

  assert_no_spurious_rd_R2: assert property (@(posedge clk) disable iff (!rstN)
    !isRead |=> !rdValid);

  assert_ident_value_R2: assert property (@(posedge clk) disable iff (!rstN)
    isIdentRead |=> rdData == CHIP_IDENT);

  assert_gap_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    isGapRead |=> rdData == '0);

  assert_break_cause_R8: assert property (@(posedge clk) disable iff (!rstN)
    isBreakCmd |=> lbusReset);

  assert_break_only_cause_R8: assert property (@(posedge clk) disable iff (!rstN)
    !isBreakCmd |=> !lbusReset);
endmodule

bind cfg_window_decoder cfg_window_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .reqWrite (reqWrite),
  .reqAddr  (reqAddr),
  .reqWdata (reqWdata),
  .rdValid  (rdValid),
  .rdData   (rdData),
  .lbusReset(lbusReset)
);

// File: tb/tb_cfg_window_decoder.sv
module tb_cfg_window_decoder;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] MAGIC = 32'hc0de0000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [20:0] reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic        rdValid;
  logic [31:0] rdData;
  logic        lbusReset;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_window_decoder dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .rdValid(rdValid),
    .rdData(rdData), .lbusReset(lbusReset)
  );

  task automatic expect32(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // All tasks start and end at a falling edge.
  task automatic wr(input logic [20:0] a, input logic [31:0] d);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = a; reqWdata = d;
    @(negedge clk);
    reqValid = 1'b0; reqWrite = 1'b0;
  endtask

  task automatic rd(input logic [20:0] a, output logic [31:0] d, output logic v);
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = a;
    @(negedge clk);
    reqValid = 1'b0;
    d = rdData; v = rdValid;
  endtask

  function automatic logic [31:0] desc(input logic [31:0] ver, input logic [31:0] kind,
                                       input logic [31:0] chk);
    return 32'h80000000 | 32'h00010000 | ver | (kind << 4) | chk;
  endfunction

  function automatic logic [31:0] expTable(input int idx);
    case (idx)
      0: return 32'hc0022d15;
      1: return desc(32'h1000, 2, 32'hc);
      2: return desc(32'h5000, 3, 32'ha);
      3: return desc(32'h1000, 6, 32'h7);
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] ctrlPat(input int i);
    return (32'(i) * 32'h01010101) ^ 32'ha5000000;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    expect32("R1 rdValid", {31'h0, rdValid}, 32'h0);
    expect32("R1 lbusReset", {31'h0, lbusReset}, 32'h0);
    for (int i = 0; i < 256; i += 51) begin
      rd(21'h800 + 21'(i*4), d, v);
      expect32("R1 ctrl reset", d, 32'h0);
    end
    for (int i = 0; i < 4; i++) begin
      rd(21'hc00 + 21'(i*4), d, v);
      expect32("R1 scratch reset", d, 32'h0);
    end

    // R2 R3 R4 table sweep
    for (int i = 0; i < 256; i++) begin
      rd(21'(i*4), d, v);
      expect32("R2 rdValid", {31'h0, v}, 32'h1);
      expect32(i < 4 ? "R3 table word" : "R4 table tail", d, expTable(i));
    end
    // R4 non-break table writes ignored
    wr(21'h000, 32'hffffffff);
    wr(21'h00c, 32'h12345678);
    wr(21'h040, 32'hdeadbeef);
    rd(21'h000, d, v); expect32("R4 ident after write", d, expTable(0));
    rd(21'h00c, d, v); expect32("R4 desc after write", d, expTable(3));
    rd(21'h040, d, v); expect32("R4 tail after write", d, 32'h0);

    // R5 control file sweep
    for (int i = 0; i < 256; i++) wr(21'h800 + 21'(i*4), ctrlPat(i));
    for (int i = 0; i < 256; i++) begin
      rd(21'h800 + 21'(i*4), d, v);
      expect32("R5 ctrl word", d, ctrlPat(i));
    end

    // R7 gap: writes ignored, reads zero
    for (int i = 0; i < 256; i++) wr(21'h400 + 21'(i*4), 32'hffffffff);
    for (int i = 0; i < 256; i++) begin
      rd(21'h400 + 21'(i*4), d, v);
      expect32("R7 gap word", d, 32'h0);
    end
    rd(21'h800, d, v); expect32("R7 ctrl untouched", d, ctrlPat(0));

    // R6 scratchpad and beyond
    for (int i = 0; i < 4; i++) wr(21'hc00 + 21'(i*4), 32'h5c000000 + 32'(i));
    wr(21'hc10, 32'hdeaddead);
    wr(21'hffc, 32'hdeaddead);
    wr(21'h1ffffc, 32'hdeaddead);
    for (int i = 0; i < 4; i++) begin
      rd(21'hc00 + 21'(i*4), d, v);
      expect32("R6 scratch word", d, 32'h5c000000 + 32'(i));
    end
    rd(21'hc10, d, v);    expect32("R6 beyond scratch", d, 32'h0);
    rd(21'hffc, d, v);    expect32("R6 local tail", d, 32'h0);
    rd(21'h1ffffc, d, v); expect32("R6 window end", d, 32'h0);

    // R8 negatives
    wr(21'h000, MAGIC ^ 32'h1);
    expect32("R8 wrong data no pulse", {31'h0, lbusReset}, 32'h0);
    wr(21'h008, MAGIC);
    expect32("R8 wrong offset no pulse", {31'h0, lbusReset}, 32'h0);
    rd(21'hc00, d, v); expect32("R8 scratch kept", d, 32'h5c000000);

    // R8 R9 break at offset 0 with a colliding scratchpad write
    wr(21'h000, MAGIC);
    expect32("R8 pulse after break", {31'h0, lbusReset}, 32'h1);
    wr(21'hc08, 32'h00001234);
    expect32("R8 pulse single cycle", {31'h0, lbusReset}, 32'h0);
    for (int i = 0; i < 4; i++) begin
      rd(21'hc00 + 21'(i*4), d, v);
      expect32("R9 scratch cleared", d, 32'h0);
    end
    rd(21'h800, d, v); expect32("R9 ctrl kept", d, ctrlPat(0));
    rd(21'hbfc, d, v); expect32("R9 ctrl kept hi", d, ctrlPat(255));

    // R10 break at offset 4 with a colliding scratchpad read
    wr(21'hc04, 32'h00000077);
    rd(21'hc04, d, v); expect32("R10 precondition", d, 32'h77);
    wr(21'h004, MAGIC);
    expect32("R8 pulse via offset 4", {31'h0, lbusReset}, 32'h1);
    rd(21'hc04, d, v);
    expect32("R10 read during pulse", d, 32'h0);
    expect32("R10 rdValid", {31'h0, v}, 32'h1);
    expect32("R8 pulse ended", {31'h0, lbusReset}, 32'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule